// File: doc/BRIEF.md
# Configuration Mailbox Transaction Engine

The block is a three-register mailbox for reaching board configuration functions: a command word, a data word and a two-bit result. Software fills the data word when it needs to, then writes the command word with the start bit set. In the next clock the engine decodes the command, runs one transaction and posts the result.

A transaction can read or update an oscillator frequency table, or read a voltage sensor. It can also raise a one-cycle shutdown or reboot request. Two selection commands, video source and display mode, are accepted and have no effect. Six main-board oscillators reset to fixed frequencies. The expansion-board oscillator and voltage tables are sized and initialised by parameters.

All registers are 32 bits wide, sit on a plain write-strobe bus and read back combinationally.

Top module: `cfg_mailbox`

## Requirements
- R1: After reset the data, command and result registers read 0. Main-board oscillator entries 0 to 5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 (Hz).
- R2: The command register sits at offset 0xA4. Its fields are: bit 31 start, bit 30 direction (1 write, 0 read), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device. Bits 31 and 19:18 always read 0; all other bits read back as written.
- R3: The result register sits at offset 0xA8. The second clock edge after a command write with start set loads it with bit 0 = 1 (done) and bit 1 = error. A direct write keeps only bits 1:0 of the written value.
- R4: A command is rejected (result 2'b11, no other effect) if any of these holds: the controller field is nonzero, the position field is nonzero, or the site is above 1. Site 0 is the main board and site 1 is the expansion board.
- R5: A read with function 1 copies an oscillator entry into the data register (offset 0xA0). Site 0 accepts devices 0 to 5. Site 1 accepts devices below DB_CLK_NUM, taking the values from DB_CLK_INIT. Any other device gives an error and leaves the data register unchanged.
- R6: A write with function 1 stores the data register into the addressed oscillator entry. The same device ranges as R5 apply.
- R7: A read with function 2 returns a voltage in microvolts: 3300000 for site 0 device 0, and DB_VOLT_INIT entries for site 1 devices below DB_VOLT_NUM. Other devices, and any write with function 2, give an error.
- R8: A write with function 8 (shutdown) or 9 (reboot) at site 0 device 0 raises the matching output for exactly one cycle. That cycle follows the clock edge that posts the result. At any other site or device, and on a read, the command gives an error and no pulse.
- R9: A write with function 7 (video source) or 11 (display mode) at site 0 device 0 succeeds and changes nothing else. At any other site or device, or on a read, it gives an error.
- R10: A command write with bit 31 clear starts nothing: the result register, the data register and both pulse outputs stay as they were.
- R11: Writes to any offset other than 0xA0, 0xA4 and 0xA8 are ignored, and such offsets read 0.
- R12: Any function code other than 1, 2, 7, 8, 9 and 11 gives an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench goes after the edges of every device range, where an off-by-one would accept a missing oscillator or reject a real one. It also checks that a failed read leaves the data register alone; a design that wrote it anyway would clobber the value staged for the next write. A reference model predicts both pulse outputs on every clock. This catches a pulse that lasts two cycles, one that fires on an error, and one that fires from a command whose start bit was clear. Readback of the command register exposes a start bit or reserved bits that were not masked.

// File: rtl/cfg_mbx_pkg.sv
package cfg_mbx_pkg;

   localparam logic [7:0] OFF_DATA = 8'hA0;
   localparam logic [7:0] OFF_CTRL = 8'hA4;
   localparam logic [7:0] OFF_STAT = 8'hA8;

   // bits 31 (start) and 19:18 are never stored
   localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;

   localparam logic [5:0] FN_OSC  = 6'd1;
   localparam logic [5:0] FN_VOLT = 6'd2;
   localparam logic [5:0] FN_VSRC = 6'd7;
   localparam logic [5:0] FN_SHUT = 6'd8;
   localparam logic [5:0] FN_BOOT = 6'd9;
   localparam logic [5:0] FN_DISP = 6'd11;

   localparam int unsigned MB_OSC_NUM = 6;
   localparam logic [31:0] MB_VOLT_UV = 32'd3300000;

   typedef struct packed {
      logic        start;
      logic        wr;
      logic [3:0]  ctl;
      logic [5:0]  fn;
      logic [1:0]  rsv;
      logic [1:0]  site;
      logic [3:0]  pos;
      logic [11:0] dev;
   } cmd_t;

   function automatic logic [31:0] mb_osc_rst(input int unsigned idx);
      if (idx == 0) return 32'd50000000;
      if (idx == 1) return 32'd23750000;
      return 32'd24000000;
   endfunction

endpackage

// File: rtl/cfg_mbx_decode.sv
module cfg_mbx_decode
   import cfg_mbx_pkg::*;
#(
   parameter int unsigned DB_CLK_NUM  = 2,
   parameter int unsigned DB_VOLT_NUM = 2,
   localparam int unsigned OSC_NUM = MB_OSC_NUM + DB_CLK_NUM,
   localparam int unsigned OSC_IW  = $clog2(OSC_NUM),
   localparam int unsigned VOLT_IW = (DB_VOLT_NUM > 1) ? $clog2(DB_VOLT_NUM) : 1
) (
   input  logic               wr,
   input  logic [3:0]         ctl,
   input  logic [5:0]         fn,
   input  logic [1:0]         site,
   input  logic [3:0]         pos,
   input  logic [11:0]        dev,
   output logic               ok,
   output logic               osc_rd,
   output logic               osc_wr,
   output logic               volt_rd,
   output logic               volt_mb,
   output logic               shut,
   output logic               boot,
   output logic [OSC_IW-1:0]  osc_idx,
   output logic [VOLT_IW-1:0] volt_idx
);

   localparam logic [11:0] MB_OSC_LIM  = 12'(MB_OSC_NUM);
   localparam logic [11:0] DB_CLK_LIM  = 12'(DB_CLK_NUM);
   localparam logic [11:0] DB_VOLT_LIM = 12'(DB_VOLT_NUM);

   logic base_ok, site_mb, site_db, dev0, mb_osc, db_osc, db_volt, nop;

   always_comb begin
      base_ok  = (ctl == 4'd0) && (pos == 4'd0) && !site[1];
      site_mb  = (site == 2'd0);
      site_db  = (site == 2'd1);
      dev0     = (dev == 12'd0);
      mb_osc   = site_mb && (dev < MB_OSC_LIM);
      db_osc   = site_db && (dev < DB_CLK_LIM);
      volt_mb  = site_mb && dev0;
      db_volt  = site_db && (dev < DB_VOLT_LIM);
      osc_idx  = mb_osc ? OSC_IW'(dev) : OSC_IW'(dev + MB_OSC_LIM);
      volt_idx = VOLT_IW'(dev);
      osc_rd   = 1'b0;
      osc_wr   = 1'b0;
      volt_rd  = 1'b0;
      nop      = 1'b0;
      shut     = 1'b0;
      boot     = 1'b0;
      if (base_ok) begin
         if (!wr) begin
            if (fn == FN_OSC)  osc_rd  = mb_osc || db_osc;
            if (fn == FN_VOLT) volt_rd = volt_mb || db_volt;
         end else begin
            if (fn == FN_OSC)  osc_wr = mb_osc || db_osc;
            if (fn == FN_VSRC || fn == FN_DISP) nop = site_mb && dev0;
            if (fn == FN_SHUT) shut = site_mb && dev0;
            if (fn == FN_BOOT) boot = site_mb && dev0;
         end
      end
      ok = osc_rd || osc_wr || volt_rd || nop || shut || boot;
   end

endmodule

// File: rtl/cfg_mbx_osc_tab.sv
module cfg_mbx_osc_tab
   import cfg_mbx_pkg::*;
#(
   parameter int unsigned DB_CLK_NUM = 2,
   parameter logic [DB_CLK_NUM*32-1:0] DB_CLK_INIT = '0,
   localparam int unsigned OSC_NUM = MB_OSC_NUM + DB_CLK_NUM,
   localparam int unsigned OSC_IW  = $clog2(OSC_NUM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [OSC_IW-1:0] idx,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);

   logic [31:0] ent [OSC_NUM];

   for (genvar g = 0; g < OSC_NUM; g++) begin : g_ent
      localparam logic [31:0] RST_VAL = (g < MB_OSC_NUM) ?
         mb_osc_rst(g) : DB_CLK_INIT[(g - MB_OSC_NUM)*32 +: 32];
      logic [31:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= RST_VAL;
         else if (we && (32'(idx) == g))
            val_q <= wdata;
      end
      assign ent[g] = val_q;
   end

   always_comb rdata = (32'(idx) < OSC_NUM) ? ent[idx] : '0;

endmodule

// File: rtl/cfg_mailbox.sv
module cfg_mailbox
   import cfg_mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DB_CLK_NUM  = 2,
   parameter int unsigned DB_VOLT_NUM = 2,
   parameter logic [DB_CLK_NUM*32-1:0]  DB_CLK_INIT  = {32'd45000000, 32'd66000000},
   parameter logic [DB_VOLT_NUM*32-1:0] DB_VOLT_INIT = {32'd1100000, 32'd900000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              shutdown_req,
   output logic              reboot_req
);

   localparam int unsigned OSC_NUM = MB_OSC_NUM + DB_CLK_NUM;
   localparam int unsigned OSC_IW  = $clog2(OSC_NUM);
   localparam int unsigned VOLT_IW = (DB_VOLT_NUM > 1) ? $clog2(DB_VOLT_NUM) : 1;

   if (ADDR_W < 8) begin : g_chk_aw
      $error("ADDR_W must cover offset 0xA8");
   end
   if (DB_CLK_NUM < 1 || DB_CLK_NUM > 64) begin : g_chk_clk
      $error("DB_CLK_NUM must be 1 to 64");
   end
   if (DB_VOLT_NUM < 1 || DB_VOLT_NUM > 64) begin : g_chk_volt
      $error("DB_VOLT_NUM must be 1 to 64");
   end

   logic [31:0] data_q;
   cmd_t        ctrl_q;
   logic [1:0]  stat_q;
   logic        pend_q;
   logic        shut_q, boot_q;

   logic wr_data, wr_ctrl, wr_stat;
   always_comb begin
      wr_data = reg_wen && (reg_addr == ADDR_W'(OFF_DATA));
      wr_ctrl = reg_wen && (reg_addr == ADDR_W'(OFF_CTRL));
      wr_stat = reg_wen && (reg_addr == ADDR_W'(OFF_STAT));
   end

   logic               ok, osc_rd, osc_wr, volt_rd, volt_mb, shut, boot;
   logic [OSC_IW-1:0]  osc_idx;
   logic [VOLT_IW-1:0] volt_idx;

   cfg_mbx_decode #(
      .DB_CLK_NUM (DB_CLK_NUM),
      .DB_VOLT_NUM(DB_VOLT_NUM)
   ) i_decode (
      .wr      (ctrl_q.wr),
      .ctl     (ctrl_q.ctl),
      .fn      (ctrl_q.fn),
      .site    (ctrl_q.site),
      .pos     (ctrl_q.pos),
      .dev     (ctrl_q.dev),
      .ok      (ok),
      .osc_rd  (osc_rd),
      .osc_wr  (osc_wr),
      .volt_rd (volt_rd),
      .volt_mb (volt_mb),
      .shut    (shut),
      .boot    (boot),
      .osc_idx (osc_idx),
      .volt_idx(volt_idx)
   );

   logic [31:0] osc_val, volt_val;

   cfg_mbx_osc_tab #(
      .DB_CLK_NUM (DB_CLK_NUM),
      .DB_CLK_INIT(DB_CLK_INIT)
   ) i_osc_tab (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (pend_q && osc_wr),
      .idx  (osc_idx),
      .wdata(data_q),
      .rdata(osc_val)
   );

   if (DB_VOLT_NUM == 1) begin : g_volt_one
      always_comb volt_val = volt_mb ? MB_VOLT_UV : DB_VOLT_INIT[31:0];
   end else begin : g_volt_many
      always_comb volt_val = volt_mb ? MB_VOLT_UV :
         ((32'(volt_idx) < DB_VOLT_NUM) ? DB_VOLT_INIT[volt_idx*32 +: 32] : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
         stat_q <= '0;
         pend_q <= 1'b0;
         shut_q <= 1'b0;
         boot_q <= 1'b0;
      end else begin
         pend_q <= wr_ctrl && reg_wdata[31];
         shut_q <= pend_q && shut;
         boot_q <= pend_q && boot;
         if (wr_ctrl)
            ctrl_q <= cmd_t'(reg_wdata & CTRL_KEEP);
         // a running transaction takes priority over a same-cycle bus write
         if (pend_q && osc_rd)
            data_q <= osc_val;
         else if (pend_q && volt_rd)
            data_q <= volt_val;
         else if (wr_data)
            data_q <= reg_wdata;
         if (pend_q)
            stat_q <= {!ok, 1'b1};
         else if (wr_stat)
            stat_q <= reg_wdata[1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFF_DATA)) reg_rdata = data_q;
      if (reg_addr == ADDR_W'(OFF_CTRL)) reg_rdata = ctrl_q;
      if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata = {30'd0, stat_q};
   end

   assign shutdown_req = shut_q;
   assign reboot_req   = boot_q;

endmodule

// File: rtl/cfg_mailbox_chk.sv
module cfg_mailbox_chk
   import cfg_mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wdata_start,
   input logic [1:0]        wdata_lo,
   input logic [31:0]       reg_rdata,
   input logic              shutdown_req,
   input logic              reboot_req,
   input logic [1:0]        stat_q,
   input logic              pend_q
);

   logic start_wr, stat_wr;
   always_comb begin
      start_wr = reg_wen && (reg_addr == ADDR_W'(OFF_CTRL)) && wdata_start;
      stat_wr  = reg_wen && (reg_addr == ADDR_W'(OFF_STAT));
   end

   AST_CTRL_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_CTRL)) |-> (reg_rdata[31] == 1'b0 && reg_rdata[19:18] == 2'b00)); // R2
   AST_START_POSTS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> ##1 stat_q[0]); // R3
   AST_STAT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !pend_q) |=> (stat_q == $past(wdata_lo))); // R3
   AST_SHUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> !shutdown_req); // R8
   AST_BOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_req |=> !reboot_req); // R8
   AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(shutdown_req && reboot_req)); // R8
   AST_PULSE_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_req || reboot_req) |-> (stat_q == 2'b01)); // R8
   AST_PULSE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_req || reboot_req) |-> $past(pend_q)); // R10

endmodule

bind cfg_mailbox cfg_mailbox_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wen     (reg_wen),
   .reg_addr    (reg_addr),
   .wdata_start (reg_wdata[31]),
   .wdata_lo    (reg_wdata[1:0]),
   .reg_rdata   (reg_rdata),
   .shutdown_req(shutdown_req),
   .reboot_req  (reboot_req),
   .stat_q      (stat_q),
   .pend_q      (pend_q)
);

// File: tb/test_cfg_mailbox.sv
`timescale 1ns/1ps
module test_cfg_mailbox;

   localparam logic [7:0] A_DATA = 8'hA0;
   localparam logic [7:0] A_CTRL = 8'hA4;
   localparam logic [7:0] A_STAT = 8'hA8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wen = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        shutdown_req, reboot_req;

   always #5 clk = ~clk;

   cfg_mailbox #(
      .ADDR_W(8), .DB_CLK_NUM(2), .DB_VOLT_NUM(2),
      .DB_CLK_INIT({32'd45000000, 32'd66000000}),
      .DB_VOLT_INIT({32'd1100000, 32'd900000})
   ) i_cfg_mailbox (
      .clk(clk), .rst_n(rst_n), .reg_wen(wen), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata),
      .shutdown_req(shutdown_req), .reboot_req(reboot_req)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   int unsigned mb [6] = '{50000000, 23750000, 24000000, 24000000, 24000000, 24000000};
   int unsigned db [2] = '{66000000, 45000000};
   int unsigned dv [2] = '{900000, 1100000};
   logic [31:0] m_data = '0;
   logic [31:0] m_ctrl = '0;
   logic [1:0]  m_stat = '0;
   logic        exp_sd = 1'b0;
   logic        exp_rb = 1'b0;

   task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // pulse outputs compared with the model on every clock
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(shutdown_req === exp_sd, "R8/R10 shutdown_req", 32'(shutdown_req), 32'(exp_sd));
         chk(reboot_req === exp_rb, "R8/R10 reboot_req", 32'(reboot_req), 32'(exp_rb));
      end
   end

   function automatic logic [31:0] mk(input bit wr, input int dcc, input int fn,
                                      input int site, input int pos, input int dev);
      return {1'b1, wr, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wen = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wen = 1'b0;
      if (a == A_DATA) m_data = d;
      if (a == A_STAT) m_stat = d[1:0];
      if (a == A_CTRL) m_ctrl = d & 32'h7FF3_FFFF;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      chk(rdata === exp, tag, rdata, exp);
   endtask

   task automatic model_exec(input logic [31:0] w, output logic sd, output logic rb);
      int dcc, fn, site, pos, dev;
      bit ok, wr;
      dcc = int'(w[29:26]); fn = int'(w[25:20]); site = int'(w[17:16]);
      pos = int'(w[15:12]); dev = int'(w[11:0]); wr = w[30];
      ok = 0; sd = 0; rb = 0;
      if (dcc == 0 && pos == 0 && site < 2) begin
         if (!wr) begin
            if (fn == 1 && site == 0 && dev < 6) begin m_data = mb[dev]; ok = 1; end
            if (fn == 1 && site == 1 && dev < 2) begin m_data = db[dev]; ok = 1; end
            if (fn == 2 && site == 0 && dev == 0) begin m_data = 3300000; ok = 1; end
            if (fn == 2 && site == 1 && dev < 2) begin m_data = dv[dev]; ok = 1; end
         end else begin
            if (fn == 1 && site == 0 && dev < 6) begin mb[dev] = m_data; ok = 1; end
            if (fn == 1 && site == 1 && dev < 2) begin db[dev] = m_data; ok = 1; end
            if ((fn == 7 || fn == 11) && site == 0 && dev == 0) ok = 1;
            if (fn == 8 && site == 0 && dev == 0) begin sd = 1; ok = 1; end
            if (fn == 9 && site == 0 && dev == 0) begin rb = 1; ok = 1; end
         end
      end
      m_stat = {~ok, 1'b1};
   endtask

   task automatic issue(input logic [31:0] w);
      logic sd, rb;
      bus_write(A_CTRL, w);
      if (w[31]) begin
         model_exec(w, sd, rb);
         @(posedge clk); #1; exp_sd = sd; exp_rb = rb;
         @(posedge clk); #1; exp_sd = 1'b0; exp_rb = 1'b0;
      end else begin
         repeat (2) @(posedge clk);
      end
   endtask

   // clear result, run one command, compare all three registers
   task automatic run(input logic [31:0] w, input string tag);
      bus_write(A_STAT, 32'd0);
      issue(w);
      rd_chk(A_DATA, m_data, {tag, " data"});
      rd_chk(A_STAT, {30'd0, m_stat}, {tag, " status"});
      rd_chk(A_CTRL, m_ctrl, {tag, " ctrl readback"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      rd_chk(A_DATA, 32'd0, "R1 data reset");
      rd_chk(A_CTRL, 32'd0, "R1 ctrl reset");
      rd_chk(A_STAT, 32'd0, "R1 status reset");

      // R1 R5 main-board oscillator reads, range edge at 6
      for (int d = 0; d < 7; d++) run(mk(0, 0, 1, 0, 0, d), "R1/R5 mb osc read");
      // R5 expansion oscillators, range edge at 2; failed read keeps data
      for (int d = 0; d < 3; d++) run(mk(0, 0, 1, 1, 0, d), "R5 db osc read");

      // R6 oscillator writes from the data register
      bus_write(A_DATA, 32'h0123_4567);
      run(mk(1, 0, 1, 0, 0, 5), "R6 mb osc write");
      bus_write(A_DATA, 32'h0BAD_F00D);
      run(mk(1, 0, 1, 1, 0, 1), "R6 db osc write");
      run(mk(1, 0, 1, 1, 0, 2), "R6 db osc write out of range");
      run(mk(0, 0, 1, 0, 0, 5), "R6 mb osc read back");
      run(mk(0, 0, 1, 1, 0, 1), "R6 db osc read back");

      // R7 voltages
      run(mk(0, 0, 2, 0, 0, 0), "R7 mb volt");
      run(mk(0, 0, 2, 1, 0, 1), "R7 db volt 1");
      run(mk(0, 0, 2, 1, 0, 0), "R7 db volt 0");
      run(mk(0, 0, 2, 1, 0, 2), "R7 db volt out of range");
      run(mk(0, 0, 2, 0, 0, 1), "R7 mb volt dev1");
      run(mk(1, 0, 2, 0, 0, 0), "R7 volt write");

      // R4 unsupported routing
      run(mk(0, 1, 1, 0, 0, 0), "R4 controller nonzero");
      run(mk(0, 0, 1, 0, 3, 0), "R4 position nonzero");
      run(mk(0, 0, 1, 2, 0, 0), "R4 site 2");
      run(mk(1, 0, 8, 3, 0, 0), "R4 site 3 shutdown");

      // R8 pulses
      run(mk(1, 0, 8, 0, 0, 0), "R8 shutdown");
      run(mk(1, 0, 9, 0, 0, 0), "R8 reboot");
      run(mk(1, 0, 8, 1, 0, 0), "R8 shutdown wrong site");
      run(mk(1, 0, 9, 0, 0, 1), "R8 reboot wrong device");
      run(mk(0, 0, 8, 0, 0, 0), "R8 shutdown read");

      // R9 accepted no-ops, tables untouched
      run(mk(1, 0, 7, 0, 0, 0), "R9 video source");
      run(mk(1, 0, 11, 0, 0, 0), "R9 display mode");
      run(mk(1, 0, 11, 0, 0, 1), "R9 display mode wrong device");
      run(mk(0, 0, 7, 0, 0, 0), "R9 video source read");
      run(mk(0, 0, 1, 0, 0, 0), "R9 osc0 unchanged");

      // R12 unknown functions
      run(mk(1, 0, 5, 0, 0, 0), "R12 function 5");
      run(mk(0, 0, 0, 0, 0, 0), "R12 function 0");
      run(mk(1, 0, 63, 0, 0, 0), "R12 function 63");

      // R2 reserved bits and start masked in readback
      run(32'hFFFF_FFFF, "R2 all ones");
      run(mk(0, 0, 1, 0, 0, 2) | 32'h000C_0000, "R2 reserved set");

      // R3 status keeps low two bits only
      bus_write(A_STAT, 32'hFFFF_FFFE);
      rd_chk(A_STAT, 32'd2, "R3 status write masked");

      // R10 command without start: nothing happens
      bus_write(A_DATA, 32'h5555_AAAA);
      issue(mk(1, 0, 8, 0, 0, 0) & 32'h7FFF_FFFF);
      issue(mk(0, 0, 1, 0, 0, 1) & 32'h7FFF_FFFF);
      rd_chk(A_STAT, 32'd2, "R10 status held");
      rd_chk(A_DATA, 32'h5555_AAAA, "R10 data held");
      rd_chk(A_CTRL, m_ctrl, "R10 ctrl stored");

      // R11 other offsets
      bus_write(8'h00, 32'hDEAD_BEEF);
      bus_write(8'h9C, 32'hDEAD_BEEF);
      bus_write(8'hAC, 32'hDEAD_BEEF);
      rd_chk(8'h00, 32'd0, "R11 offset 0x00");
      rd_chk(8'h9C, 32'd0, "R11 offset 0x9C");
      rd_chk(8'hAC, 32'd0, "R11 offset 0xAC");
      rd_chk(A_DATA, 32'h5555_AAAA, "R11 data untouched");
      rd_chk(A_STAT, 32'd2, "R11 status untouched");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule